// File: doc/BRIEF.md
# Oversampled Modified-Miller Frame Decoder

This block recovers the reader-to-card bit stream of a proximity-card link from an oversampled record of the carrier-pause signal. Samples arrive packed eight to a byte. A fixed number of adjacent sample bits (two or four, chosen at build time) covers one bit period. The decoder sorts each bit period into one of the three Miller sequences X, Y or Z. It turns each sequence into a logic value, using the previous bit wherever sequence Y makes the meaning depend on it. It stops when it sees the end-of-frame pattern.

Decoded bits are grouped nine at a time: eight data bits followed by one parity bit. Data bits go into an internal byte buffer. Parity bits go into a bitmap with one bit per byte. When the frame ends, the block raises a one-cycle done pulse and presents the number of complete bytes and the number of leftover bits. Both counts hold until the next frame is started. Any byte and its parity bit can be read back through a combinational read port. A start strobe clears the buffers and counters before each frame. Bits that do not fit in the buffer are dropped and raise an overflow flag.

Top module: `miller_rx_decoder`

## Requirements
- R1: Parameter OSR (2 or 4) sets the samples per bit period. Each input byte holds 8/OSR bit periods, and these are taken starting from bits [OSR-1:0] and moving upward.
- R2: Each bit period's sample group is classified as follows. With OSR=2, value 2 is X, 0 is Y and 1 is Z. With OSR=4, value 4 is X, 0 is Y and 1 is Z. Any other value is handled as Y.
- R3: X decodes to logic 1 and Z decodes to logic 0.
- R4: Y decodes to logic 0 if the previous decoded bit was 1. If the previous bit was 0, Y ends the frame and is not counted as a bit. The previous bit is 0 at frame start, so a leading Y gives an empty frame.
- R5: Decoded bit number n (counted from 0) goes to byte n/9. Positions 0 to 7 of n%9 are data bits, stored at bit n%9 of that byte, so the byte fills LSB first. Position 8 is that byte's parity bit, read on rd_parity.
- R6: At frame end, frame_done is high for exactly one cycle. byte_count equals bits/9 and bit_count equals bits%9, and both hold until frame_start.
- R7: If a byte accepted with in_last set is used up without an end marker, the frame ends after that byte's last bit period.
- R8: After the frame ends, in_ready stays high. Further sample bytes, including the rest of the byte that held the end marker, are accepted and change neither the counts nor the buffer.
- R9: Bits beyond MAX_BYTES*9 are dropped and overflow is set. The counts then read MAX_BYTES and 0.
- R10: Reset and frame_start clear all bytes and parity bits, both counts, overflow and the previous bit, and return the block to accepting samples.
- R11: Once a sample byte is accepted, in_ready stays low for the 8/OSR cycles that decode one bit period each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Clears state to prepare for a new frame |
| in_valid | input | 1 | Sample byte valid |
| in_ready | output | 1 | Decoder can take a sample byte |
| in_data | input | 8 | Packed samples, lowest bit period in the low bits |
| in_last | input | 1 | Marks the final sample byte of the record |
| frame_done | output | 1 | One-cycle pulse at frame end |
| byte_count | output | $clog2(MAX_BYTES+1) | Complete bytes decoded |
| bit_count | output | 4 | Leftover bits after the complete bytes |
| overflow | output | 1 | Buffer capacity exceeded |
| rd_addr | input | $clog2(MAX_BYTES) | Read index into the byte buffer |
| rd_data | output | 8 | Data byte at rd_addr |
| rd_parity | output | 1 | Parity bit of byte rd_addr |

## Verification
The bench targets the dependence of Y on the previous bit. A decoder that ignores this either never ends a frame, or ends it on the first Y that follows a 1, and the counts come out wrong. Unknown sample groups are placed after both a 1 and a 0, which exposes a design that treats them as Z or X. Frames are chosen so the ninth bit must land in the parity bitmap rather than in the next byte, and so the end marker falls in the middle of an input byte with trailing data that must be discarded. Further cases cover buffer overflow, residue left by a long frame being cleared for a short one, in_last ending a frame that has no end marker, and both oversampling rates.

// File: rtl/miller_rx_decoder.sv
module miller_rx_decoder #(
  parameter int OSR       = 2,
  parameter int MAX_BYTES = 256,
  localparam int GPB = 8 / OSR,
  localparam int GW  = (GPB > 1) ? $clog2(GPB) : 1,
  localparam int AW  = $clog2(MAX_BYTES),
  localparam int CW  = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          frame_done,
  output logic [CW-1:0] byte_count,
  output logic [3:0]    bit_count,
  output logic          overflow,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          rd_parity
);

  localparam logic [OSR-1:0] CODE_X = (OSR == 4) ? OSR'(4) : OSR'(2);
  localparam logic [OSR-1:0] CODE_Z = OSR'(1);

  typedef enum logic [1:0] {S_ACCEPT, S_PROC, S_DONE} st_t;

  st_t              st;
  logic [7:0]       sh;
  logic [GW-1:0]    grp_cnt;
  logic             last_q;
  logic             prev_bit;
  logic [7:0]       dmem [MAX_BYTES];
  logic [MAX_BYTES-1:0] pmap;
  logic [CW-1:0]    byte_idx;
  logic [3:0]       pos;

  wire [OSR-1:0] grp     = sh[OSR-1:0];
  wire           is_x    = (grp == CODE_X);
  wire           is_z    = (grp == CODE_Z);
  wire           eof     = !is_x && !is_z && !prev_bit;
  wire           dbit    = is_x;
  wire           full    = (byte_idx == CW'(MAX_BYTES));
  wire           grp_end = (grp_cnt == GW'(GPB - 1));
  wire [AW-1:0]  widx    = byte_idx[AW-1:0];

  assign in_ready   = (st != S_PROC);
  assign byte_count = byte_idx;
  assign bit_count  = pos;
  assign rd_data    = dmem[rd_addr];
  assign rd_parity  = pmap[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n || frame_start) begin
      st         <= S_ACCEPT;
      sh         <= '0;
      grp_cnt    <= '0;
      last_q     <= 1'b0;
      prev_bit   <= 1'b0;
      byte_idx   <= '0;
      pos        <= '0;
      overflow   <= 1'b0;
      frame_done <= 1'b0;
      pmap       <= '0;
      for (int i = 0; i < MAX_BYTES; i++) dmem[i] <= '0;
    end else begin
      frame_done <= 1'b0;
      case (st)
        S_ACCEPT: if (in_valid) begin
          sh      <= in_data;
          grp_cnt <= '0;
          last_q  <= in_last;
          st      <= S_PROC;
        end
        S_PROC: begin
          if (eof) begin
            st         <= S_DONE;
            frame_done <= 1'b1;
          end else begin
            prev_bit <= dbit;
            if (full) begin
              overflow <= 1'b1;
            end else if (pos == 4'd8) begin
              pmap[widx] <= dbit;
              pos        <= '0;
              byte_idx   <= byte_idx + 1'b1;
            end else begin
              dmem[widx][pos[2:0]] <= dbit;
              pos                  <= pos + 1'b1;
            end
            sh      <= sh >> OSR;
            grp_cnt <= grp_cnt + 1'b1;
            if (grp_end) begin
              if (last_q) begin
                st         <= S_DONE;
                frame_done <= 1'b1;
              end else begin
                st <= S_ACCEPT;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/miller_rx_decoder_chk.sv
module miller_rx_decoder_chk #(
  parameter int MAX_BYTES = 256,
  parameter int CW        = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          in_valid,
  input logic          in_ready,
  input logic          frame_done,
  input logic [CW-1:0] byte_count,
  input logic [3:0]    bit_count,
  input logic          overflow,
  input logic          busy,
  input logic          finished
);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_hold_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && !frame_start) |=> ($stable(byte_count) && $stable(bit_count) && $stable(overflow)));

  p_bit_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count <= 4'd8);

  p_ovf_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (byte_count == CW'(MAX_BYTES) && bit_count == 4'd0));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (byte_count == '0 && bit_count == 4'd0 && !overflow && !frame_done));

  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !busy && !finished && !frame_start) |=> !in_ready);

endmodule

bind miller_rx_decoder miller_rx_decoder_chk #(.MAX_BYTES(MAX_BYTES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
  .in_ready(in_ready), .frame_done(frame_done), .byte_count(byte_count),
  .bit_count(bit_count), .overflow(overflow),
  .busy(st == S_PROC), .finished(st == S_DONE)
);

// File: tb/sim_miller_rx_decoder.sv
module sim_miller_rx_decoder;
  localparam int MB = 4;

  logic clk = 0, rst_n = 0, fs = 0;
  always #2 clk = ~clk;

  logic v0 = 0, l0 = 0, r0, d0, o0, rp0;
  logic v1 = 0, l1 = 0, r1, d1, o1, rp1;
  logic [7:0] dat0 = 0, dat1 = 0, rd0, rd1;
  logic [2:0] bc0, bc1;
  logic [3:0] bt0, bt1;
  logic [1:0] ra0 = 0, ra1 = 0;

  miller_rx_decoder #(.OSR(2), .MAX_BYTES(MB)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(fs), .in_valid(v0), .in_ready(r0),
    .in_data(dat0), .in_last(l0), .frame_done(d0), .byte_count(bc0), .bit_count(bt0),
    .overflow(o0), .rd_addr(ra0), .rd_data(rd0), .rd_parity(rp0));

  miller_rx_decoder #(.OSR(4), .MAX_BYTES(MB)) u1 (
    .clk(clk), .rst_n(rst_n), .frame_start(fs), .in_valid(v1), .in_ready(r1),
    .in_data(dat1), .in_last(l1), .frame_done(d1), .byte_count(bc1), .bit_count(bt1),
    .overflow(o1), .rd_addr(ra1), .rd_data(rd1), .rd_parity(rp1));

  int checks = 0, errors = 0;
  int dc0 = 0, dc1 = 0;
  always @(negedge clk) begin
    if (d0) dc0++;
    if (d1) dc1++;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int eb[MB], ep[MB], en, eovf;

  function automatic int code(int sel, byte c);
    if (c == "X") return sel ? 4 : 2;
    if (c == "Z") return 1;
    if (c == "J") return sel ? 10 : 3;
    return 0;
  endfunction

  function automatic string pad(int sel, string s);
    string t = s;
    int g = sel ? 2 : 4;
    while (t.len() % g != 0) t = {t, "Y"};
    return t;
  endfunction

  task automatic model(string s);
    int prev = 0, b;
    en = 0; eovf = 0;
    for (int k = 0; k < MB; k++) begin eb[k] = 0; ep[k] = 0; end
    for (int i = 0; i < s.len(); i++) begin
      if (s[i] == "X") b = 1;
      else if (s[i] == "Z") b = 0;
      else begin
        if (prev == 0) break;
        b = 0;
      end
      prev = b;
      if (en < MB * 9) begin
        if (en % 9 == 8) ep[en / 9] = b;
        else eb[en / 9] = eb[en / 9] | (b << (en % 9));
        en++;
      end else eovf = 1;
    end
  endtask

  task automatic start_frame();
    @(negedge clk); fs = 1;
    @(negedge clk); fs = 0;
  endtask

  task automatic feed(int sel, string s, bit use_last);
    int g = sel ? 2 : 4, w = sel ? 4 : 2, nb = s.len() / g;
    for (int b = 0; b < nb; b++) begin
      logic [7:0] d = 0;
      for (int j = 0; j < g; j++) d = d | 8'(code(sel, s[b * g + j]) << (j * w));
      @(negedge clk);
      if (sel) begin v1 = 1; dat1 = d; l1 = use_last && (b == nb - 1); end
      else     begin v0 = 1; dat0 = d; l0 = use_last && (b == nb - 1); end
      while (!(sel ? r1 : r0)) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    v0 = 0; v1 = 0; l0 = 0; l1 = 0;
  endtask

  task automatic run(string tag, int sel, string s, bit use_last);
    string p = pad(sel, s);
    int base;
    start_frame();
    base = sel ? dc1 : dc0;
    model(p);
    feed(sel, p, use_last);
    repeat (12) @(negedge clk);
    check({tag, " R6 done pulses"}, (sel ? dc1 : dc0) - base, 1);
    check({tag, " R6 byte_count"}, sel ? bc1 : bc0, en / 9);
    check({tag, " R6 bit_count"}, sel ? bt1 : bt0, en % 9);
    check({tag, " R9 overflow"}, sel ? o1 : o0, eovf);
    check({tag, " R8 ready after end"}, sel ? r1 : r0, 1);
    for (int k = 0; k < MB; k++) begin
      if (sel) ra1 = 2'(k); else ra0 = 2'(k);
      #1;
      check({tag, " R5 data byte"}, sel ? rd1 : rd0, eb[k]);
      check({tag, " R5 parity bit"}, sel ? rp1 : rp0, ep[k]);
    end
  endtask

  task automatic t_reset();
    check("R10 reset ready", r0, 1);
    check("R10 reset done", d0, 0);
    check("R10 reset bytes", bc0, 0);
    check("R10 reset bits", bt0, 0);
    check("R10 reset ovf", o0, 0);
  endtask

  task automatic t_busy();
    start_frame();
    @(negedge clk); v0 = 1; dat0 = 8'h55;
    @(posedge clk);
    @(negedge clk); v0 = 0;
    check("R11 ready low c1", r0, 0);
    @(negedge clk); check("R11 ready low c2", r0, 0);
    @(negedge clk); check("R11 ready low c3", r0, 0);
    @(negedge clk); check("R11 ready low c4", r0, 0);
    @(negedge clk); check("R11 ready back", r0, 1);
  endtask

  initial begin
    string big;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    run("R1 R3 basic", 0, "XZXXZZZXXZXZY", 0);
    run("R4 y after one", 0, "XYXYZZY", 0);
    run("R4 empty", 0, "YXXX", 0);
    run("R2 junk", 0, "XJZJXX", 0);
    run("R7 last", 0, "XZXZ", 1);
    run("R8 ignore", 0, "ZYXXXXXXXXXXXX", 0);
    big = "";
    for (int i = 0; i < 45; i++) big = {big, "X"};
    run("R9 overflow", 0, {big, "ZZY"}, 0);
    run("R10 clear", 0, "ZY", 0);
    run("R1 R2 osr4 basic", 1, "XZXXZZZXXZXZY", 0);
    run("R2 osr4 junk", 1, "XJZJ", 0);
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule